// File: doc/BRIEF.md
# Multiplexed Host Bus Register Interface with Shadow Time Transfer

This block is the host-facing register file of a real-time clock. The host uses a single 8-bit bus for both addresses and data. An address/data select line decides whether an access targets the internal address pointer or the byte that the pointer selects. The pointer keeps its value between accesses, so a burst of data accesses all goes to one location. A strap input chooses between two strobe styles. In one style separate read and write strobes are used. In the other, a single data strobe is qualified by a read/write level.

The timekeeping counters sit outside this block. They are seen as a bank with a capture input, which gives the live clock and timer values, and a load output, which is one data word plus a one-cycle enable. Three command codes in the pointer select the clock bank, the timer bank, or both. The next data access then decides the direction. A data read copies the live values into the shadow bytes. A data write copies the shadow bytes into the counters, and its data byte is discarded.

Every copy finishes in one cycle that is free of the counters' 100 Hz update. A status lock bit guards the write-direction copies and the trim byte. A power-fail input isolates the bus at once. A two-step write to status byte 2 returns the status bytes to their initial values.

Top module: `rtc_hostbus`

## Requirements
- R1: A write with `adSel`=0 loads the byte into the address pointer. A read with `adSel`=0 returns the pointer on `busOut` with `busOe`=1. `busOe` is 1 only while a read is active, with `csN`=0 and `rdN`=0.
- R2: A read or write with `adSel`=1 goes to the byte the pointer selects, and the pointer is left unchanged. Repeated data accesses keep going to that byte. The user bytes 0x50–0x5F hold whatever was written to them.
- R3: The pointer codes are 0xF1 (clock), 0xF2 (timer) and 0xF0 (both). After one of them, a data read copies `clockNow` byte i into address 0x20+i (i=0..8), `timerNow` byte i into 0x40+i (i=0..3), or both. Any bank that was not selected keeps its bytes.
- R4: After a command code, a data write raises `clockLoadEn` and/or `timerLoadEn` for exactly one cycle. During that cycle `clockLoadData` byte i equals shadow byte 0x20+i, and `timerLoadData` byte i equals shadow byte 0x40+i. The written data byte is discarded, and the pointer keeps the command code.
- R5: Bit 5 of status byte 0x00 is the lock bit. While it is 1, write-direction copies do not happen and writes to the trim byte at 0x10 are ignored. Read-direction copies still happen.
- R6: Writing 0xF0–0xF2 as data (`adSel`=1) stores the byte as normal data and starts no copy.
- R7: While `pfN`=0, `busOe` is 0 in the same cycle, and all accesses are ignored. Stored bytes, including the user bytes, are kept.
- R8: Write a 1 into bit 4 of 0x02, then write a byte with bit 4 clear. Status 0x00 becomes 0x01 (tuning bit 0 set, lock clear), and 0x01 and 0x02 become 0x00.
- R9: With `modeSel`=1, an access happens only while `csN`=0 and `rdN`=0 (the data strobe). `wrN`=1 means read and `wrN`=0 means write. `csN`=0 with `wrN`=0 while `rdN`=1 does nothing.
- R10: A write commits when `csN` or the write strobe rises, whichever comes first. It stores the data byte sampled in the last cycle the write was active.
- R11: A copy never happens in a cycle with `updateTick`=1. A copy due in such a cycle happens in the next cycle, using the values present then.
- R12: Only 0x00–0x02, 0x10, 0x20–0x28, 0x30–0x34, 0x40–0x43 and 0x50–0x5F are storage. Data reads of any other address return 0x00, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus strobes are sampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Strobe style: 0 = separate read/write strobes, 1 = data strobe plus read/write level |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wrN | input | 1 | Write strobe (mode 0, active low) or direction level (mode 1, 1 = read) |
| adSel | input | 1 | 0 = access the address pointer, 1 = access data |
| pfN | input | 1 | Active-low power fail |
| busIn | input | 8 | Host bus, inbound |
| busOut | output | 8 | Host bus, outbound |
| busOe | output | 1 | Output enable for the host bus |
| updateTick | input | 1 | One-cycle pulse at each 100 Hz counter update |
| clockNow | input | 72 | Live clock bytes, byte i in bits 8i+7:8i |
| timerNow | input | 32 | Live timer bytes |
| clockLoadData | output | 72 | Shadow clock bytes offered for loading |
| timerLoadData | output | 32 | Shadow timer bytes offered for loading |
| clockLoadEn | output | 1 | One-cycle clock load enable |
| timerLoadEn | output | 1 | One-cycle timer load enable |

## Verification
A shadow copy and the counter update can fall due in the same clock edge. The copy must then wait a cycle. The bench makes this happen for both directions. For a capture, it raises `updateTick` exactly at the edge where the capture would execute, and changes `clockNow` only after that edge. The shadow bytes must then hold the new values, not the old ones. For a load, it holds the tick at the edge where the load enable would rise. The enable must stay low during the tick and rise in the following cycle.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;

  // Fixed map points that the command decoder and the status logic depend on
  localparam int ADDR_STAT0    = 'h00;
  localparam int ADDR_STAT1    = 'h01;
  localparam int ADDR_STAT2    = 'h02;
  localparam int ADDR_TRIM     = 'h10;
  localparam int CLOCK_BASE    = 'h20;
  localparam int ALARM_BASE    = 'h30;
  localparam int TIMER_BASE    = 'h40;
  localparam int USER_BASE     = 'h50;
  localparam int CMD_BOTH      = 'hF0;
  localparam int CMD_CLOCK     = 'hF1;
  localparam int CMD_TIMER     = 'hF2;
  localparam int LOCK_BIT      = 5;
  localparam int INIT_BIT      = 4;
  localparam logic [7:0] STAT0_INIT = 8'h01;

  // Control-to-datapath strobes, each valid for one cycle
  typedef struct packed {
    logic latchAddr;
    logic writeData;
    logic capClock;
    logic capTimer;
    logic ldClock;
    logic ldTimer;
  } busStrobe_t;

endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       adSel,
  input  logic       pfN,
  input  logic       updateTick,
  input  logic [7:0] busIn,
  input  logic [7:0] addrLatch,
  input  logic       lockBit,
  output busStrobe_t strobe,
  output logic [7:0] wrHold,
  output logic       busOe
);

  localparam int PEND_W = 4;
  localparam int P_CAPC = 0;
  localparam int P_CAPT = 1;
  localparam int P_LDC  = 2;
  localparam int P_LDT  = 3;

  logic readActive, writeActive, prevRead, prevWrite, heldAd;
  logic writeEnd, readStart, isCmd, hitClock, hitTimer, execNow;
  logic readCmd, writeCmd;
  logic [PEND_W-1:0] pend, newPend;
  int cmdCode;

  // Strobe decode for the two host styles
  always_comb begin
    if (modeSel) begin
      readActive  = pfN && !csN && !rdN && wrN;
      writeActive = pfN && !csN && !rdN && !wrN;
    end else begin
      readActive  = pfN && !csN && !rdN;
      writeActive = pfN && !csN && !wrN;
    end
  end

  always_comb begin
    cmdCode  = int'(addrLatch);
    hitClock = (cmdCode == CMD_BOTH) || (cmdCode == CMD_CLOCK);
    hitTimer = (cmdCode == CMD_BOTH) || (cmdCode == CMD_TIMER);
    isCmd    = hitClock || hitTimer;
  end

  assign writeEnd  = prevWrite && !writeActive && pfN;
  assign readStart = readActive && !prevRead;
  assign readCmd   = readStart && adSel && isCmd;
  assign writeCmd  = writeEnd && heldAd && isCmd;
  assign execNow   = !updateTick;

  always_comb begin
    newPend         = '0;
    newPend[P_CAPC] = readCmd && hitClock;
    newPend[P_CAPT] = readCmd && hitTimer;
    newPend[P_LDC]  = writeCmd && hitClock;
    newPend[P_LDT]  = writeCmd && hitTimer;
  end

  always_comb begin
    strobe.latchAddr = writeEnd && !heldAd;
    strobe.writeData = writeEnd && heldAd && !isCmd;
    strobe.capClock  = execNow && pend[P_CAPC];
    strobe.capTimer  = execNow && pend[P_CAPT];
    strobe.ldClock   = execNow && pend[P_LDC] && !lockBit;
    strobe.ldTimer   = execNow && pend[P_LDT] && !lockBit;
  end

  assign busOe = readActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRead  <= 1'b0;
      prevWrite <= 1'b0;
      heldAd    <= 1'b0;
      wrHold    <= '0;
      pend      <= '0;
    end else begin
      prevRead  <= readActive;
      prevWrite <= writeActive;
      if (writeActive) begin
        wrHold <= busIn;
        heldAd <= adSel;
      end
      if (execNow) pend <= newPend;
      else         pend <= pend | newPend;
    end
  end

endmodule

// File: rtl/rtc_bus_dp.sv
module rtc_bus_dp
  import rtc_bus_pkg::*;
#(
  parameter int CLOCK_BYTES = 9,
  parameter int TIMER_BYTES = 4,
  parameter int ALARM_BYTES = 5,
  parameter int USER_BYTES  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobe_t               strobe,
  input  logic [7:0]               wrHold,
  input  logic                     adSel,
  input  logic [CLOCK_BYTES*8-1:0] clockNow,
  input  logic [TIMER_BYTES*8-1:0] timerNow,
  output logic [7:0]               busOut,
  output logic [7:0]               addrLatch,
  output logic                     lockBit,
  output logic [CLOCK_BYTES*8-1:0] clockShadow,
  output logic [TIMER_BYTES*8-1:0] timerShadow
);

  localparam int SPAN  = USER_BASE + USER_BYTES;
  localparam int IDX_W = $clog2(SPAN);

  logic [7:0] regs [SPAN];
  logic [IDX_W-1:0] idx;
  logic mapped, trimBlocked, initFire;
  logic [7:0] readByte;

  function automatic logic isMapped(input int a);
    return (a <= ADDR_STAT2) || (a == ADDR_TRIM) ||
           (a >= CLOCK_BASE && a < CLOCK_BASE + CLOCK_BYTES) ||
           (a >= ALARM_BASE && a < ALARM_BASE + ALARM_BYTES) ||
           (a >= TIMER_BASE && a < TIMER_BASE + TIMER_BYTES) ||
           (a >= USER_BASE  && a < SPAN);
  endfunction

  assign mapped      = isMapped(int'(addrLatch));
  assign idx         = addrLatch[IDX_W-1:0];
  assign lockBit     = regs[ADDR_STAT0][LOCK_BIT];
  assign trimBlocked = lockBit && (int'(addrLatch) == ADDR_TRIM);
  assign initFire    = (int'(addrLatch) == ADDR_STAT2) &&
                       regs[ADDR_STAT2][INIT_BIT] && !wrHold[INIT_BIT];
  assign readByte    = mapped ? regs[idx] : 8'h00;
  assign busOut      = adSel ? readByte : addrLatch;

  for (genvar gc = 0; gc < CLOCK_BYTES; gc++) begin : g_clkShadow
    assign clockShadow[gc*8 +: 8] = regs[CLOCK_BASE + gc];
  end
  for (genvar gt = 0; gt < TIMER_BYTES; gt++) begin : g_tmrShadow
    assign timerShadow[gt*8 +: 8] = regs[TIMER_BASE + gt];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLatch <= '0;
      for (int i = 0; i < SPAN; i++) regs[i] <= '0;
    end else begin
      if (strobe.latchAddr) addrLatch <= wrHold;
      if (strobe.writeData && mapped && !trimBlocked) begin
        if (initFire) begin
          regs[ADDR_STAT0] <= STAT0_INIT;
          regs[ADDR_STAT1] <= 8'h00;
          regs[ADDR_STAT2] <= 8'h00;
        end else begin
          regs[idx] <= wrHold;
        end
      end
      if (strobe.capClock)
        for (int i = 0; i < CLOCK_BYTES; i++) regs[CLOCK_BASE + i] <= clockNow[i*8 +: 8];
      if (strobe.capTimer)
        for (int i = 0; i < TIMER_BYTES; i++) regs[TIMER_BASE + i] <= timerNow[i*8 +: 8];
    end
  end

endmodule

// File: rtl/rtc_hostbus.sv
module rtc_hostbus
  import rtc_bus_pkg::*;
#(
  parameter int CLOCK_BYTES = 9,
  parameter int TIMER_BYTES = 4,
  parameter int ALARM_BYTES = 5,
  parameter int USER_BYTES  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     modeSel,
  input  logic                     csN,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic                     adSel,
  input  logic                     pfN,
  input  logic [7:0]               busIn,
  output logic [7:0]               busOut,
  output logic                     busOe,
  input  logic                     updateTick,
  input  logic [CLOCK_BYTES*8-1:0] clockNow,
  input  logic [TIMER_BYTES*8-1:0] timerNow,
  output logic [CLOCK_BYTES*8-1:0] clockLoadData,
  output logic [TIMER_BYTES*8-1:0] timerLoadData,
  output logic                     clockLoadEn,
  output logic                     timerLoadEn
);

  busStrobe_t strobe;
  logic [7:0] wrHold, addrLatch;
  logic       lockBit;

  rtc_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .rdN(rdN), .wrN(wrN),
    .adSel(adSel), .pfN(pfN), .updateTick(updateTick), .busIn(busIn),
    .addrLatch(addrLatch), .lockBit(lockBit), .strobe(strobe), .wrHold(wrHold),
    .busOe(busOe)
  );

  rtc_bus_dp #(
    .CLOCK_BYTES(CLOCK_BYTES), .TIMER_BYTES(TIMER_BYTES),
    .ALARM_BYTES(ALARM_BYTES), .USER_BYTES(USER_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrHold(wrHold), .adSel(adSel),
    .clockNow(clockNow), .timerNow(timerNow), .busOut(busOut), .addrLatch(addrLatch),
    .lockBit(lockBit), .clockShadow(clockLoadData), .timerShadow(timerLoadData)
  );

  assign clockLoadEn = strobe.ldClock;
  assign timerLoadEn = strobe.ldTimer;

endmodule

// File: rtl/rtc_hostbus_chk.sv
module rtc_hostbus_chk (
  input logic clk,
  input logic rstN,
  input logic pfN,
  input logic csN,
  input logic rdN,
  input logic busOe,
  input logic updateTick,
  input logic clockLoadEn,
  input logic timerLoadEn,
  input logic lockBit
);

  assert_bus_hiz_pf_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pfN |-> !busOe);

  assert_oe_needs_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!csN && !rdN));

  assert_no_xfer_on_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    updateTick |-> !(clockLoadEn || timerLoadEn));

  assert_lock_blocks_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |-> !(clockLoadEn || timerLoadEn));

  assert_load_pair_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clockLoadEn) |=> !clockLoadEn || updateTick == 1'b0);

endmodule

bind rtc_hostbus rtc_hostbus_chk u_chk (
  .clk(clk), .rstN(rstN), .pfN(pfN), .csN(csN), .rdN(rdN), .busOe(busOe),
  .updateTick(updateTick), .clockLoadEn(clockLoadEn), .timerLoadEn(timerLoadEn),
  .lockBit(lockBit)
);

// File: tb/rtc_hostbus_tb.sv
module rtc_hostbus_tb;

  localparam int CB = 9;
  localparam int TB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1, adSel = 1'b0, pfN = 1'b1;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic busOe;
  logic updateTick = 1'b0;
  logic [CB*8-1:0] clockNow = '0;
  logic [TB*8-1:0] timerNow = '0;
  logic [CB*8-1:0] clockLoadData;
  logic [TB*8-1:0] timerLoadData;
  logic clockLoadEn, timerLoadEn;

  int checks = 0;
  int errors = 0;
  int loadSeen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rtc_hostbus u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .rdN(rdN), .wrN(wrN),
    .adSel(adSel), .pfN(pfN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .updateTick(updateTick), .clockNow(clockNow), .timerNow(timerNow),
    .clockLoadData(clockLoadData), .timerLoadData(timerLoadData),
    .clockLoadEn(clockLoadEn), .timerLoadEn(timerLoadEn)
  );

  always @(negedge clk) if (clockLoadEn || timerLoadEn) loadSeen++;

  task automatic checkEq(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit refMapped(input int a);
    return (a <= 'h02) || (a == 'h10) || (a >= 'h20 && a <= 'h28) ||
           (a >= 'h30 && a <= 'h34) || (a >= 'h40 && a <= 'h43) ||
           (a >= 'h50 && a <= 'h5F);
  endfunction

  task automatic idleBus();
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busWrite(input logic ad, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; adSel = ad; busIn = d;
    if (modeSel) begin rdN = 1'b0; wrN = 1'b0; end
    else         begin rdN = 1'b1; wrN = 1'b0; end
    @(negedge clk);
    @(negedge clk);
    idleBus();
    @(negedge clk);
  endtask

  task automatic busRead(input logic ad, output logic [7:0] d, output logic oe);
    @(negedge clk);
    csN = 1'b0; adSel = ad; rdN = 1'b0; wrN = 1'b1;
    @(negedge clk);
    #1; d = busOut; oe = busOe;
    idleBus();
    @(negedge clk);
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] d);
    logic oe;
    busWrite(1'b0, a);
    busRead(1'b1, d, oe);
  endtask

  task automatic writeAt(input logic [7:0] a, input logic [7:0] d);
    busWrite(1'b0, a);
    busWrite(1'b1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    checkEq("R1 reset oe", {7'b0, busOe}, 8'h00);
    busRead(1'b0, d, oe);
    checkEq("R1 reset pointer", d, 8'h00);
    checkEq("R1 oe during read", {7'b0, oe}, 8'h01);

    // Sweep: pointer readback and data storage / unmapped behaviour
    for (int a = 3; a < 256; a++) begin
      busWrite(1'b0, 8'(a));
      busRead(1'b0, d, oe);
      checkEq("R1 pointer readback", d, 8'(a));
      busWrite(1'b1, 8'(a) ^ 8'h5A);
      busRead(1'b1, d, oe);
      checkEq(refMapped(a) ? "R2 data store" : "R12 unmapped",
              d, refMapped(a) ? (8'(a) ^ 8'h5A) : 8'h00);
    end

    // Repeated data accesses stay on the same address
    busWrite(1'b0, 8'h57);
    busWrite(1'b1, 8'h11);
    busWrite(1'b1, 8'h22);
    busRead(1'b1, d, oe);
    checkEq("R2 same address", d, 8'h22);
    busRead(1'b0, d, oe);
    checkEq("R2 pointer kept", d, 8'h57);
    readAt(8'h58, d);
    checkEq("R2 neighbour untouched", d, 8'h58 ^ 8'h5A);

    // Clock-only capture
    for (int i = 0; i < CB; i++) clockNow[i*8 +: 8] = 8'h80 + 8'(i);
    for (int i = 0; i < TB; i++) timerNow[i*8 +: 8] = 8'hC0 + 8'(i);
    writeAt(8'h40, 8'h99);
    busWrite(1'b0, 8'hF1);
    busRead(1'b1, d, oe);
    for (int i = 0; i < CB; i++) begin
      readAt(8'h20 + 8'(i), d);
      checkEq("R3 clock capture", d, 8'h80 + 8'(i));
    end
    readAt(8'h40, d);
    checkEq("R3 timer untouched by clock cmd", d, 8'h99);

    // Timer-only capture
    busWrite(1'b0, 8'hF2);
    busRead(1'b1, d, oe);
    for (int i = 0; i < TB; i++) begin
      readAt(8'h40 + 8'(i), d);
      checkEq("R3 timer capture", d, 8'hC0 + 8'(i));
    end

    // Both-bank capture
    clockNow[7:0] = 8'h31;
    timerNow[7:0] = 8'h32;
    busWrite(1'b0, 8'hF0);
    busRead(1'b1, d, oe);
    readAt(8'h20, d);
    checkEq("R3 both clock", d, 8'h31);
    readAt(8'h40, d);
    checkEq("R3 both timer", d, 8'h32);

    // Clock load by write-direction command
    for (int i = 0; i < CB; i++) writeAt(8'h20 + 8'(i), 8'h10 + 8'(i));
    busWrite(1'b0, 8'hF1);
    busWrite(1'b1, 8'hEE);
    #1;
    checkEq("R4 clock load enable", {7'b0, clockLoadEn}, 8'h01);
    checkEq("R4 timer load quiet", {7'b0, timerLoadEn}, 8'h00);
    for (int i = 0; i < CB; i++)
      checkEq("R4 clock load data", clockLoadData[i*8 +: 8], 8'h10 + 8'(i));
    @(negedge clk); #1;
    checkEq("R4 single pulse", {7'b0, clockLoadEn}, 8'h00);
    busRead(1'b0, d, oe);
    checkEq("R4 pointer keeps command", d, 8'hF1);

    // Both-bank load
    busWrite(1'b0, 8'hF0);
    busWrite(1'b1, 8'h00);
    #1;
    checkEq("R4 both clock en", {7'b0, clockLoadEn}, 8'h01);
    checkEq("R4 both timer en", {7'b0, timerLoadEn}, 8'h01);
    checkEq("R4 timer load data", timerLoadData[7:0], 8'h32);

    // Command codes written as data do not transfer
    busWrite(1'b0, 8'h5C);
    loadSeen = 0;
    busWrite(1'b1, 8'hF1);
    repeat (2) @(negedge clk);
    checkEq("R6 no load from data F1", 8'(loadSeen), 8'h00);
    busRead(1'b1, d, oe);
    checkEq("R6 F1 stored as data", d, 8'hF1);

    // Lock bit
    writeAt(8'h10, 8'h42);
    writeAt(8'h00, 8'h20);
    writeAt(8'h10, 8'h77);
    readAt(8'h10, d);
    checkEq("R5 trim write blocked", d, 8'h42);
    loadSeen = 0;
    busWrite(1'b0, 8'hF0);
    busWrite(1'b1, 8'h00);
    repeat (3) @(negedge clk);
    checkEq("R5 load blocked", 8'(loadSeen), 8'h00);
    clockNow[7:0] = 8'h47;
    busWrite(1'b0, 8'hF1);
    busRead(1'b1, d, oe);
    readAt(8'h20, d);
    checkEq("R5 capture while locked", d, 8'h47);
    writeAt(8'h00, 8'h00);
    writeAt(8'h10, 8'h77);
    readAt(8'h10, d);
    checkEq("R5 trim after unlock", d, 8'h77);

    // Initialisation sequence
    writeAt(8'h00, 8'h3E);
    writeAt(8'h01, 8'hFF);
    writeAt(8'h02, 8'h10);
    busWrite(1'b1, 8'h00);
    readAt(8'h00, d);
    checkEq("R8 status0 init", d, 8'h01);
    readAt(8'h01, d);
    checkEq("R8 status1 init", d, 8'h00);
    readAt(8'h02, d);
    checkEq("R8 status2 init", d, 8'h00);

    // Power fail
    writeAt(8'h55, 8'hA5);
    @(negedge clk);
    csN = 1'b0; adSel = 1'b1; rdN = 1'b0;
    @(negedge clk); #1;
    checkEq("R7 oe before fail", {7'b0, busOe}, 8'h01);
    pfN = 1'b0; #1;
    checkEq("R7 oe drops at once", {7'b0, busOe}, 8'h00);
    idleBus();
    busWrite(1'b1, 8'h00);
    busWrite(1'b0, 8'h10);
    busRead(1'b1, d, oe);
    checkEq("R7 no drive in fail", {7'b0, oe}, 8'h00);
    pfN = 1'b1;
    busRead(1'b0, d, oe);
    checkEq("R7 pointer kept", d, 8'h55);
    busRead(1'b1, d, oe);
    checkEq("R7 user byte kept", d, 8'hA5);

    // Write commit ordering
    busWrite(1'b0, 8'h51);
    @(negedge clk);
    csN = 1'b0; adSel = 1'b1; wrN = 1'b0; busIn = 8'h61;
    @(negedge clk); busIn = 8'h62;
    @(negedge clk); wrN = 1'b1; busIn = 8'h63;
    @(negedge clk); csN = 1'b1;
    @(negedge clk);
    busRead(1'b1, d, oe);
    checkEq("R10 write strobe first", d, 8'h62);
    @(negedge clk);
    csN = 1'b0; adSel = 1'b1; wrN = 1'b0; busIn = 8'h71;
    @(negedge clk); csN = 1'b1; busIn = 8'h72;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk);
    busRead(1'b1, d, oe);
    checkEq("R10 select first", d, 8'h71);

    // Data-strobe style
    modeSel = 1'b1;
    writeAt(8'h5A, 8'h3C);
    readAt(8'h5A, d);
    checkEq("R9 strobe style write/read", d, 8'h3C);
    @(negedge clk);
    csN = 1'b0; adSel = 1'b1; rdN = 1'b1; wrN = 1'b0; busIn = 8'hC3;
    repeat (2) @(negedge clk);
    idleBus();
    @(negedge clk);
    busRead(1'b1, d, oe);
    checkEq("R9 no strobe no write", d, 8'h3C);
    busRead(1'b0, d, oe);
    checkEq("R9 pointer read", d, 8'h5A);
    modeSel = 1'b0;

    // Capture coinciding with an update
    clockNow[7:0] = 8'h01;
    busWrite(1'b0, 8'hF1);
    @(negedge clk);
    csN = 1'b0; adSel = 1'b1; rdN = 1'b0;
    @(negedge clk);
    updateTick = 1'b1;
    @(negedge clk);
    updateTick = 1'b0; clockNow[7:0] = 8'h02; idleBus();
    @(negedge clk);
    readAt(8'h20, d);
    checkEq("R11 capture deferred past tick", d, 8'h02);

    // Load coinciding with an update
    busWrite(1'b0, 8'hF1);
    busWrite(1'b1, 8'h00);
    updateTick = 1'b1; #1;
    checkEq("R11 no load during tick", {7'b0, clockLoadEn}, 8'h00);
    @(negedge clk);
    updateTick = 1'b0; #1;
    checkEq("R11 load after tick", {7'b0, clockLoadEn}, 8'h01);
    @(negedge clk); #1;
    checkEq("R11 load once", {7'b0, clockLoadEn}, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule